// File: doc/BRIEF.md
# Geometry Command Queue with Status and Interrupt

This block sits in front of a 3D geometry engine and buffers the commands that software sends to it. Each write into the command-port window becomes one queued entry. The 7-bit command code is taken from the write address, and the write data supplies up to four parameter bytes. A drain engine takes entries from the head of the queue in arrival order. It presents each entry on an execute strobe and then stays occupied for a cycle cost that depends on the command code. Commands whose cost is zero are never stored.

A 32-bit status word reports the following, with each field at the bit position the register layout fixes:

- the effective number of entries
- full, fewer-than-half and empty flags
- a busy flag
- two stack flags raised by the engine
- the interrupt mode

The interrupt request is a one-cycle pulse. It is evaluated only after a drain step, after a write to the upper status half, and after an interrupt acknowledge. A swap-buffers command parks the drain engine when it is taken from the queue. The swap stays pending, and counts as one extra entry, until a vertical-blank pulse arrives.

Top module: `geo_cmd_queue`

## Requirements
- R1: A write on `wr_en` queues command code `wr_addr[8:2]`. `wr_addr[1:0]` is ignored. A 32-bit write (`wr_wide`=1) carries all four data bytes as parameters. A 16-bit write carries `wr_data[15:0]` as parameters 0 and 1, and parameters 2 and 3 read zero. When executed, `exec_param[7:0]` holds parameter 0 and `exec_param[31:24]` holds parameter 3.
- R2: The command costs are:
  - codes 0x10–0x1F cost 17
  - codes 0x20–0x2B cost 8
  - codes 0x30–0x3F cost 4
  - codes 0x40, 0x41, 0x50 and 0x60 cost 1
  - code 0x70 costs 103, 0x71 costs 9 and 0x72 costs 10
  - every other code costs 0

  A zero-cost write is discarded without touching the queue or the overflow flag.
- R3: Entries leave in arrival order, one per `exec_valid` pulse. After an entry of cost C is executed, the next one is executed no earlier than C cycles later, and exactly C cycles later when entries are waiting.
- R4: The status fields are:
  - `status[24:16]` is the effective count: stored entries plus one while a swap is pending
  - bit 24 is also set when the store is full
  - bit 25 is set while the effective count is below DEPTH/2
  - bit 26 is set when the effective count is zero
- R5: Executing code 0x50 sets a swap-pending state. While the swap is pending no further entry is executed. A `vblank` pulse clears the swap, and draining then restarts.
- R6: `status[27]` (busy) is 1 while entries are stored, while an entry's cost is still running, or while a swap is pending. Otherwise it is 0.
- R7: The interrupt mode is `status[31:30]`. `irq_req` pulses in the cycle after a drain step, an upper-half status write or an `irq_ack`, and only if one of these conditions holds:
  - mode is 1 and the effective count is below DEPTH/2
  - mode is 2 and the effective count is zero

  Modes 0 and 3 never request an interrupt.
- R8: An upper-half status write stores `hi_data[15:14]` as the mode. All other status bits are unaffected.
- R9: `stk_set[0]` sets the stack-error bit `status[15]`, and `stk_set[1]` sets the projection-level bit `status[13]`. A lower-half write with `lo_data[15]`=1 clears both bits. No other lower-half bit has any effect.
- R10: A non-zero-cost write that arrives while DEPTH entries are stored is dropped, and it sets `overflow`. `overflow` stays set until reset.
- R11: After reset the following hold:
  - the queue is empty and no swap is pending
  - the mode is 0, `overflow` is 0 and `irq_req` is 0
  - `status` reads 0x0600_0000

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command-port write strobe |
| wr_addr | input | 9 | Offset in the command-port window |
| wr_wide | input | 1 | 1 = 32-bit write, 0 = 16-bit write |
| wr_data | input | 32 | Write data (parameter bytes) |
| lo_we | input | 1 | Lower status half write strobe |
| lo_data | input | 16 | Lower status half write data |
| hi_we | input | 1 | Upper status half write strobe |
| hi_data | input | 16 | Upper status half write data |
| irq_ack | input | 1 | Interrupt flag acknowledge |
| vblank | input | 1 | Vertical-blank pulse |
| stk_set | input | 2 | Stack flag set pulses from the engine |
| status | output | 32 | Status word |
| irq_req | output | 1 | Interrupt request pulse |
| overflow | output | 1 | Sticky drop-on-full flag |
| exec_valid | output | 1 | Entry handed to the engine this cycle |
| exec_code | output | 7 | Command code of that entry |
| exec_param | output | 32 | Parameter bytes of that entry |

## Verification
Some behaviour is checked by the assertions on every cycle:
- the queue never accepts an entry while it is full, and its count moves only on a push or a pop
- a drain step of cost greater than one is never followed at once by another step
- the swap-pending state only rises right after a swap command is executed
- `overflow` never falls and `irq_req` never fires in modes 0 or 3

Other behaviour is shown only by the bench's scenarios:
- the exact cost spacing between executions and the arrival order of codes and parameters
- the +1 count of a pending swap and its release on `vblank`
- the status bit positions, including the full count of DEPTH+1
- the interrupt pulses after each kind of evaluation event

// File: rtl/geo_cmdq_pkg.sv
package geo_cmdq_pkg;

    localparam int CODE_W = 7;
    localparam int COST_W = 7;
    localparam int STAT_CNT_W = 9;
    localparam logic [CODE_W-1:0] CODE_SWAP = 7'h50;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [3:0][7:0]   prm;
    } cmd_entry_t;

    typedef enum logic [1:0] {
        IRQ_OFF     = 2'd0,
        IRQ_LT_HALF = 2'd1,
        IRQ_EMPTY   = 2'd2,
        IRQ_RSVD    = 2'd3
    } irq_mode_e;

    // Cycles the engine stays occupied per command code; zero means not queued.
    function automatic logic [COST_W-1:0] cmd_cost(input logic [CODE_W-1:0] c);
        logic [COST_W-1:0] r;
        r = '0;
        if (c >= 7'h10 && c <= 7'h1F)      r = 7'd17;
        else if (c >= 7'h20 && c <= 7'h2B) r = 7'd8;
        else if (c >= 7'h30 && c <= 7'h3F) r = 7'd4;
        else if (c == 7'h40 || c == 7'h41 || c == CODE_SWAP || c == 7'h60) r = 7'd1;
        else if (c == 7'h70)               r = 7'd103;
        else if (c == 7'h71)               r = 7'd9;
        else if (c == 7'h72)               r = 7'd10;
        return r;
    endfunction

endpackage

// File: rtl/geo_cmdq_fifo.sv
module geo_cmdq_fifo
    import geo_cmdq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  cmd_entry_t       din,
    input  logic             pop,
    output cmd_entry_t       head,
    output logic [CNT_W-1:0] cnt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    cmd_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign head = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt < CNT_W'(DEPTH))); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push == pop) |=> $stable(cnt)); // R4
endmodule

// File: rtl/geo_cmdq_drain.sv
module geo_cmdq_drain
    import geo_cmdq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_empty,
    input  cmd_entry_t head,
    input  logic       vblank,
    output logic       pop,
    output logic       exec_valid,
    output cmd_entry_t exec_entry,
    output logic       swap_pend,
    output logic       cost_running
);
    logic [COST_W-1:0] timer;

    assign cost_running = (timer != '0);
    assign pop = !fifo_empty && !cost_running && !swap_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer      <= '0;
            swap_pend  <= 1'b0;
            exec_valid <= 1'b0;
            exec_entry <= '0;
        end else begin
            exec_valid <= pop;
            if (pop) begin
                exec_entry <= head;
                timer      <= cmd_cost(head.code) - 1'b1;
            end else if (cost_running) begin
                timer <= timer - 1'b1;
            end
            if (pop && head.code == CODE_SWAP) swap_pend <= 1'b1;
            else if (vblank)                   swap_pend <= 1'b0;
        end
    end

    AST_COST_GAP: assert property (@(posedge clk) disable iff (rst)
        (pop && cmd_cost(head.code) > 7'd1) |=> !pop); // R3
    AST_SWAP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $rose(swap_pend) |-> $past(pop && head.code == CODE_SWAP)); // R5
endmodule

// File: rtl/geo_cmdq_status.sv
module geo_cmdq_status
    import geo_cmdq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             swap_pend,
    input  logic             busy,
    input  logic             eval_evt,
    input  logic             lo_we,
    input  logic             lo_clr,
    input  logic             hi_we,
    input  logic [1:0]       hi_mode,
    input  logic [1:0]       stk_set,
    output logic [31:0]      status,
    output logic             irq_req
);
    localparam int REP_W = $clog2(DEPTH + 2);
    localparam logic [REP_W-1:0] HALF = REP_W'(DEPTH / 2);

    irq_mode_e        mode;
    logic             stk_err, proj_lvl, eval_q;
    logic [REP_W-1:0] rep;
    logic             full, lt_half, empty;
    logic [STAT_CNT_W-1:0] cnt_f;

    assign rep     = REP_W'(fifo_cnt) + REP_W'(swap_pend);
    assign full    = (fifo_cnt == CNT_W'(DEPTH));
    assign lt_half = (rep < HALF);
    assign empty   = (rep == '0);
    assign cnt_f   = STAT_CNT_W'(rep);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= IRQ_OFF;
            stk_err  <= 1'b0;
            proj_lvl <= 1'b0;
            eval_q   <= 1'b0;
        end else begin
            eval_q <= eval_evt;
            if (hi_we) mode <= irq_mode_e'(hi_mode);
            if (lo_we && lo_clr) begin
                stk_err  <= 1'b0;
                proj_lvl <= 1'b0;
            end else begin
                if (stk_set[0]) stk_err  <= 1'b1;
                if (stk_set[1]) proj_lvl <= 1'b1;
            end
        end
    end

    assign irq_req = eval_q && ((mode == IRQ_LT_HALF && lt_half) ||
                                (mode == IRQ_EMPTY && empty));

    assign status = {mode, 2'b00, busy, empty, lt_half, (full | cnt_f[8]), cnt_f[7:0],
                     stk_err, 1'b0, proj_lvl, 5'b0, 6'b0, 1'b0, 1'b0};

    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (status[31:30] == 2'd1 || status[31:30] == 2'd2)); // R7
    AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (lo_we && lo_clr) |=> (status[15] == 1'b0 && status[13] == 1'b0)); // R9
endmodule

// File: rtl/geo_cmd_queue.sv
module geo_cmd_queue
    import geo_cmdq_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [8:0]  wr_addr,
    input  logic        wr_wide,
    input  logic [31:0] wr_data,
    input  logic        lo_we,
    input  logic [15:0] lo_data,
    input  logic        hi_we,
    input  logic [15:0] hi_data,
    input  logic        irq_ack,
    input  logic        vblank,
    input  logic [1:0]  stk_set,
    output logic [31:0] status,
    output logic        irq_req,
    output logic        overflow,
    output logic        exec_valid,
    output logic [6:0]  exec_code,
    output logic [31:0] exec_param
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    cmd_entry_t       wr_entry, head, exec_entry;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_full, costly, push, pop;
    logic             swap_pend, cost_running, busy;
    logic             unused_bits;

    assign unused_bits = ^{wr_addr[1:0], lo_data[14:0], hi_data[13:0]};

    assign wr_entry.code = wr_addr[8:2];
    assign wr_entry.prm  = wr_wide ? wr_data : {16'h0000, wr_data[15:0]};

    assign costly    = (cmd_cost(wr_entry.code) != '0);
    assign fifo_full = (fifo_cnt == CNT_W'(DEPTH));
    assign push      = wr_en && costly && !fifo_full;

    always_ff @(posedge clk) begin
        if (rst)                           overflow <= 1'b0;
        else if (wr_en && costly && fifo_full) overflow <= 1'b1;
    end

    geo_cmdq_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fifo_i (
        .clk(clk), .rst(rst), .push(push), .din(wr_entry),
        .pop(pop), .head(head), .cnt(fifo_cnt)
    );

    geo_cmdq_drain drain_i (
        .clk(clk), .rst(rst), .fifo_empty(fifo_cnt == '0), .head(head),
        .vblank(vblank), .pop(pop), .exec_valid(exec_valid),
        .exec_entry(exec_entry), .swap_pend(swap_pend),
        .cost_running(cost_running)
    );

    assign busy = cost_running || (fifo_cnt != '0) || swap_pend;

    geo_cmdq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) status_i (
        .clk(clk), .rst(rst), .fifo_cnt(fifo_cnt), .swap_pend(swap_pend),
        .busy(busy), .eval_evt(pop || hi_we || irq_ack),
        .lo_we(lo_we), .lo_clr(lo_data[15]), .hi_we(hi_we),
        .hi_mode(hi_data[15:14]), .stk_set(stk_set),
        .status(status), .irq_req(irq_req)
    );

    assign exec_code  = exec_entry.code;
    assign exec_param = exec_entry.prm;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R10
endmodule

// File: tb/geo_cmd_queue_tb_top.sv
module geo_cmd_queue_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1, wr_en = 0, wr_wide = 0, lo_we = 0, hi_we = 0;
    logic        irq_ack = 0, vblank = 0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] lo_data = '0, hi_data = '0;
    logic [1:0]  stk_set = '0;
    logic [31:0] status, exec_param;
    logic        irq_req, overflow, exec_valid;
    logic [6:0]  exec_code;

    geo_cmd_queue #(.DEPTH(256)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide),
        .wr_data(wr_data), .lo_we(lo_we), .lo_data(lo_data), .hi_we(hi_we),
        .hi_data(hi_data), .irq_ack(irq_ack), .vblank(vblank), .stk_set(stk_set),
        .status(status), .irq_req(irq_req), .overflow(overflow),
        .exec_valid(exec_valid), .exec_code(exec_code), .exec_param(exec_param)
    );

    int checks = 0, failures = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd_write(input logic [8:0] a, input logic w, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_wide = w; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic hi_write(input logic [15:0] d);
        hi_we = 1; hi_data = d; @(negedge clk); hi_we = 0;
    endtask

    task automatic lo_write(input logic [15:0] d);
        lo_we = 1; lo_data = d; @(negedge clk); lo_we = 0;
    endtask

    task automatic pulse_vblank();
        vblank = 1; @(negedge clk); vblank = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1; @(negedge clk); irq_ack = 0;
    endtask

    // {addr[8:0], wide, data[31:0], accepted}
    localparam logic [42:0] VEC [7] = '{
        {9'h040, 1'b0, 32'hCAFE_BEEF, 1'b1},
        {9'h1C8, 1'b1, 32'h1122_3344, 1'b1},
        {9'h000, 1'b0, 32'h0000_5555, 1'b0},
        {9'h0BC, 1'b1, 32'h0F0F_0F0F, 1'b0},
        {9'h104, 1'b1, 32'hA5A5_0F0F, 1'b1},
        {9'h1FC, 1'b0, 32'h0000_7777, 1'b0},
        {9'h0C2, 1'b0, 32'h9999_1234, 1'b1}
    };

    function automatic int ref_cost(input logic [6:0] c);
        case (c)
            7'h40, 7'h41, 7'h50, 7'h60: return 1;
            7'h70: return 103;
            7'h71: return 9;
            7'h72: return 10;
            default: begin
                if (c[6:4] == 3'd1) return 17;
                if (c[6:4] == 3'd2 && c[3:0] <= 4'hB) return 8;
                if (c[6:4] == 3'd3) return 4;
                return 0;
            end
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [6:0]  q_code [8];
        logic [31:0] q_prm  [8];
        int          qn;
        logic [6:0]  got_code [8];
        logic [31:0] got_prm  [8];
        int          got_cyc  [8];
        int          gn;

        idle(3);
        rst = 0;
        idle(1);
        check("R11", "reset status", status, 32'h0600_0000);
        check("R11", "reset irq", {31'b0, irq_req}, 0);
        check("R11", "reset overflow", {31'b0, overflow}, 0);

        // Stall the engine with a swap
        cmd_write(9'h140, 0, 0);
        idle(1);
        check("R5", "swap executed", {exec_valid, 24'b0, exec_code}, {1'b1, 24'b0, 7'h50});
        check("R5", "swap counts one", {23'b0, status[24:16]}, 1);
        check("R6", "busy while swap", {31'b0, status[27]}, 1);

        // Table walk while stalled
        qn = 0;
        for (int i = 0; i < 7; i++) begin
            logic [8:0]  a;
            logic        w, acc;
            logic [31:0] d;
            {a, w, d, acc} = VEC[i];
            cmd_write(a, w, d);
            check("R2", "cost table agrees", {31'b0, acc}, {31'b0, ref_cost(a[8:2]) != 0});
            if (acc) begin
                q_code[qn] = a[8:2];
                q_prm[qn]  = w ? d : {16'h0, d[15:0]};
                qn++;
            end
            check("R4", "count after write", {23'b0, status[24:16]}, qn + 1);
        end
        idle(3);
        check("R5", "no drain while pending", {23'b0, status[24:16]}, qn + 1);

        // Release and collect executions
        pulse_vblank();
        gn = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (exec_valid && gn < 8) begin
                got_code[gn] = exec_code;
                got_prm[gn]  = exec_param;
                got_cyc[gn]  = cyc;
                gn++;
            end
        end
        check("R3", "executed count", gn, qn);
        for (int j = 0; j < 4; j++) begin
            check("R1", "exec code order", {25'b0, got_code[j]}, {25'b0, q_code[j]});
            check("R1", "exec params", got_prm[j], q_prm[j]);
        end
        for (int j = 1; j < 4; j++)
            check("R3", "cost spacing", got_cyc[j] - got_cyc[j-1], ref_cost(q_code[j-1]));
        check("R6", "idle after drain", status, 32'h0600_0000);

        // Interrupt modes
        hi_write(16'h4000);
        check("R7", "mode1 irq on hi write", {31'b0, irq_req}, 1);
        check("R8", "mode field", {30'b0, status[31:30]}, 1);
        idle(1);
        check("R7", "irq is a pulse", {31'b0, irq_req}, 0);
        hi_write(16'h8000);
        check("R7", "mode2 irq when empty", {31'b0, irq_req}, 1);
        cmd_write(9'h140, 0, 0);
        idle(1);
        check("R7", "mode2 no irq with swap pending", {30'b0, exec_valid, irq_req}, 2'b10);
        hi_write(16'h8000);
        check("R7", "mode2 no irq count one", {31'b0, irq_req}, 0);
        pulse_vblank();
        idle(1);
        pulse_ack();
        check("R7", "mode2 irq on ack", {31'b0, irq_req}, 1);
        hi_write(16'h4000);
        cmd_write(9'h100, 0, 16'h0001);
        idle(1);
        check("R7", "mode1 irq on drain step", {30'b0, exec_valid, irq_req}, 2'b11);
        hi_write(16'h0000);
        pulse_ack();
        check("R7", "mode0 silent", {31'b0, irq_req}, 0);
        hi_write(16'hFFFF);
        check("R8", "only mode bits written", status, 32'hC600_0000);
        pulse_ack();
        check("R7", "mode3 silent", {31'b0, irq_req}, 0);
        hi_write(16'h0000);

        // Stack flags
        stk_set = 2'b11; idle(1); stk_set = 2'b00;
        check("R9", "stack flags set", status & 32'h0000_A000, 32'h0000_A000);
        lo_write(16'h7FFF);
        check("R9", "low write without bit15", status & 32'h0000_FFFF, 32'h0000_A000);
        lo_write(16'h8000);
        check("R9", "bit15 clears both", status & 32'h0000_FFFF, 32'h0000_0000);

        // Fill to capacity behind a swap
        cmd_write(9'h140, 0, 0);
        idle(1);
        for (int i = 0; i < 256; i++) cmd_write(9'h100, 0, i);
        check("R4", "full count field", {23'b0, status[24:16]}, 32'h101);
        check("R4", "full flags", {29'b0, status[26:24]}, 3'b001);
        cmd_write(9'h000, 0, 0);
        check("R2", "zero cost no overflow", {31'b0, overflow}, 0);
        cmd_write(9'h104, 1, 32'hDEAD_0000);
        check("R10", "overflow set", {31'b0, overflow}, 1);
        check("R10", "count unchanged", {23'b0, status[24:16]}, 32'h101);
        pulse_vblank();
        idle(300);
        check("R6", "drained idle", status, 32'h0600_0000);
        check("R10", "overflow sticky", {31'b0, overflow}, 1);

        rst = 1; idle(1); rst = 0; idle(1);
        check("R11", "reset clears overflow", {31'b0, overflow}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule